// File: doc/BRIEF.md
# Quadrature Position Counter with Compare Window and Event Interrupts

This block is a signed up/down position counter for an incremental encoder. An upstream stage turns the encoder's A/B pair into single count steps, each with a direction flag. The block applies each step to the count and keeps the count between a programmable low bound and a programmable high bound. Running past either bound wraps the count and records an overflow or underflow event. A synchronisation event loads a programmable start value. It can come from the encoder's index pulse, from the index pulse qualified by a gate input, or from a chosen edge of the gate input.

Two compare registers can be rewritten while counting continues. Together they form an inclusive window. A registered compare output is high while the count lies inside that window. Five event sources set sticky status bits: entry into the compare window, overflow, underflow, the count stepping onto zero, and a reversal of step direction. Software clears these bits by writing ones. A per-bit mask selects which bits drive the interrupt line.

The step input is a valid/ready stream. The block never applies back-pressure, so `step_ready` is always high and every cycle with `step_valid` high is accepted. The remaining pins are plain levels that are sampled every clock.

Top module: `encoder_event_counter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `count` is 0, `cmp_out` is 0, `ev_status` is 0, `irq` is 0 and `step_ready` is 1.
- R2: `step_ready` is always 1. A step with `step_up`=1 adds one to `count` at the next clock edge, and a step with `step_up`=0 subtracts one. With no step and no synchronisation event, `count` holds.
- R3: An up step taken while `count` >= `lim_hi` (signed) sets `count` to `lim_lo` instead of incrementing it, and sets status bit 1 (overflow).
- R4: A down step taken while `count` <= `lim_lo` (signed) sets `count` to `lim_hi` instead of decrementing it, and sets status bit 2 (underflow).
- R5: A step whose resulting count is 0 sets status bit 3 (zero). A wrap that lands on 0 also counts.
- R6: A step whose direction differs from that of the previous accepted step sets status bit 4 (direction reversal). The first step after reset never sets it.
- R7: A write with `cmp_wr_en`=1 loads `cmp_wr_data` into the window low register when `cmp_wr_sel`=0, and into the window high register when `cmp_wr_sel`=1. The new value is used from the next clock. `cmp_out` is registered: in each cycle it shows whether the previous cycle's count lay inside [low, high], signed and inclusive. Reset values are low=0 and high=-1, which gives an empty window.
- R8: Status bit 0 (compare) is set at the same clock edge at which `cmp_out` rises.
- R9: `sync_mode` selects the synchronisation source: 0 none; 1 a rising edge of `enc_idx`; 2 a rising edge of `enc_idx` while `gate_in` is 1; 3 an edge of `gate_in`, rising if `sync_fall`=0 and falling if `sync_fall`=1. In the cycle where that edge is seen, the next clock loads `start_val` into `count`. Any step in that cycle is dropped, and the load raises none of status bits 1 to 4.
- R10: Status bits are sticky. A 1 in bit i of `st_clr` clears bit i at the next clock, unless the same event occurs in that cycle, in which case the bit stays set.
- R11: `irq` is high exactly when some bit of `ev_status` is 1 and the matching bit of `irq_mask` is 1, in the same cycle as the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | A count step is offered this cycle |
| step_ready | output | 1 | Step accepted; always 1 |
| step_up | input | 1 | Step direction, 1 = up |
| enc_idx | input | 1 | Encoder index (N) pulse |
| gate_in | input | 1 | Digital qualifier / trigger input |
| sync_mode | input | 2 | Synchronisation source select |
| sync_fall | input | 1 | Mode 3 edge: 0 rising, 1 falling |
| start_val | input | W | Value loaded on synchronisation |
| lim_lo | input | W | Low count bound (signed) |
| lim_hi | input | W | High count bound (signed) |
| cmp_wr_en | input | 1 | Compare register write strobe |
| cmp_wr_sel | input | 1 | 0 window low, 1 window high |
| cmp_wr_data | input | W | Compare write data (signed) |
| st_clr | input | 5 | Write-one-to-clear for status bits |
| irq_mask | input | 5 | Interrupt enable per status bit |
| count | output | W | Current count (signed) |
| cmp_out | output | 1 | Registered compare-window output |
| ev_status | output | 5 | Sticky events: 0 compare, 1 overflow, 2 underflow, 3 zero, 4 reversal |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted count register shows on `count` one clock later. It also moves `cmp_out` one cycle after that. A wrong wrap decision shows up as a mistaken bound value and a missing or extra overflow/underflow bit in the same cycle. A lost direction history or compare state appears only when the next step or window entry arrives, as a wrong bit 4 or bit 0. The bench therefore replays long step sequences that cross both bounds and the window many times, so each such fault is exposed within a few vectors.

// File: rtl/qec_pkg.sv
`timescale 1ns/1ps
package qec_pkg;
  typedef enum logic [1:0] {
    SYNC_OFF       = 2'd0,
    SYNC_IDX       = 2'd1,
    SYNC_IDX_GATED = 2'd2,
    SYNC_GATE_EDGE = 2'd3
  } sync_mode_e;

  localparam int EV_CMP  = 0;
  localparam int EV_OVF  = 1;
  localparam int EV_UNF  = 2;
  localparam int EV_ZERO = 3;
  localparam int EV_DIR  = 4;
  localparam int NEV     = 5;
endpackage

// File: rtl/qec_sync.sv
`timescale 1ns/1ps
module qec_sync
  import qec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_idx,
  input  logic       gate_in,
  input  logic [1:0] sync_mode,
  input  logic       sync_fall,
  output logic       sync_pulse
);
  logic idx_q, gate_q;
  logic idx_rise, gate_rise, gate_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      idx_q  <= enc_idx;
      gate_q <= gate_in;
    end
  end

  assign idx_rise  = enc_idx & ~idx_q;
  assign gate_rise = gate_in & ~gate_q;
  assign gate_fall = ~gate_in & gate_q;

  always_comb begin
    unique case (sync_mode_e'(sync_mode))
      SYNC_OFF:       sync_pulse = 1'b0;
      SYNC_IDX:       sync_pulse = idx_rise;
      SYNC_IDX_GATED: sync_pulse = idx_rise & gate_in;
      default:        sync_pulse = sync_fall ? gate_fall : gate_rise;
    endcase
  end
endmodule

// File: rtl/qec_core.sv
`timescale 1ns/1ps
module qec_core #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_valid,
  input  logic                step_up,
  input  logic                sync_pulse,
  input  logic signed [W-1:0] start_val,
  input  logic signed [W-1:0] lim_lo,
  input  logic signed [W-1:0] lim_hi,
  output logic signed [W-1:0] count,
  output logic                ev_ovf,
  output logic                ev_unf,
  output logic                ev_zero,
  output logic                ev_dir
);
  logic signed [W-1:0] nxt;
  logic take, last_up, have_dir;

  assign take = step_valid & ~sync_pulse;

  always_comb begin
    nxt    = count;
    ev_ovf = 1'b0;
    ev_unf = 1'b0;
    if (sync_pulse) begin
      nxt = start_val;
    end else if (step_valid) begin
      if (step_up) begin
        if (count >= lim_hi) begin
          nxt    = lim_lo;
          ev_ovf = 1'b1;
        end else begin
          nxt = count + W'(1);
        end
      end else begin
        if (count <= lim_lo) begin
          nxt    = lim_hi;
          ev_unf = 1'b1;
        end else begin
          nxt = count - W'(1);
        end
      end
    end
    ev_zero = take && (nxt == '0);
    ev_dir  = take && have_dir && (step_up != last_up);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      last_up  <= 1'b0;
      have_dir <= 1'b0;
    end else begin
      count <= nxt;
      if (take) begin
        last_up  <= step_up;
        have_dir <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qec_cmp.sv
`timescale 1ns/1ps
module qec_cmp #(
  parameter int W    = 16,
  parameter int NCMP = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic signed [W-1:0] wr_data,
  input  logic signed [W-1:0] count,
  output logic                cmp_out,
  output logic                cmp_rise
);
  localparam int SELW = (NCMP > 1) ? $clog2(NCMP) : 1;

  logic signed [W-1:0] bound [NCMP];
  logic in_win;

  for (genvar g = 0; g < NCMP; g++) begin : g_bound
    always_ff @(posedge clk) begin
      if (!rst_n)
        bound[g] <= (g == 0) ? '0 : '1;
      else if (wr_en && (SELW'(wr_sel) == SELW'(g)))
        bound[g] <= wr_data;
    end
  end

  assign in_win   = (count >= bound[0]) && (count <= bound[NCMP-1]);
  assign cmp_rise = in_win & ~cmp_out;

  always_ff @(posedge clk) begin
    if (!rst_n) cmp_out <= 1'b0;
    else        cmp_out <= in_win;
  end
endmodule

// File: rtl/qec_status.sv
`timescale 1ns/1ps
module qec_status
  import qec_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev,
  input  logic [NEV-1:0] clr,
  input  logic [NEV-1:0] mask,
  output logic [NEV-1:0] status,
  output logic           irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | ev;
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/encoder_event_counter.sv
`timescale 1ns/1ps
module encoder_event_counter
  import qec_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_valid,
  output logic                step_ready,
  input  logic                step_up,
  input  logic                enc_idx,
  input  logic                gate_in,
  input  logic [1:0]          sync_mode,
  input  logic                sync_fall,
  input  logic signed [W-1:0] start_val,
  input  logic signed [W-1:0] lim_lo,
  input  logic signed [W-1:0] lim_hi,
  input  logic                cmp_wr_en,
  input  logic                cmp_wr_sel,
  input  logic signed [W-1:0] cmp_wr_data,
  input  logic [NEV-1:0]      st_clr,
  input  logic [NEV-1:0]      irq_mask,
  output logic signed [W-1:0] count,
  output logic                cmp_out,
  output logic [NEV-1:0]      ev_status,
  output logic                irq
);
  logic sync_pulse;
  logic ev_ovf, ev_unf, ev_zero, ev_dir, cmp_rise;
  logic [NEV-1:0] ev_vec;

  assign step_ready = 1'b1;

  qec_sync u_sync (
    .clk(clk), .rst_n(rst_n), .enc_idx(enc_idx), .gate_in(gate_in),
    .sync_mode(sync_mode), .sync_fall(sync_fall), .sync_pulse(sync_pulse)
  );

  qec_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_up(step_up),
    .sync_pulse(sync_pulse), .start_val(start_val), .lim_lo(lim_lo),
    .lim_hi(lim_hi), .count(count), .ev_ovf(ev_ovf), .ev_unf(ev_unf),
    .ev_zero(ev_zero), .ev_dir(ev_dir)
  );

  qec_cmp #(.W(W), .NCMP(2)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_en(cmp_wr_en), .wr_sel(cmp_wr_sel),
    .wr_data(cmp_wr_data), .count(count), .cmp_out(cmp_out),
    .cmp_rise(cmp_rise)
  );

  always_comb begin
    ev_vec          = '0;
    ev_vec[EV_CMP]  = cmp_rise;
    ev_vec[EV_OVF]  = ev_ovf;
    ev_vec[EV_UNF]  = ev_unf;
    ev_vec[EV_ZERO] = ev_zero;
    ev_vec[EV_DIR]  = ev_dir;
  end

  qec_status u_stat (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .clr(st_clr), .mask(irq_mask),
    .status(ev_status), .irq(irq)
  );
endmodule

// File: rtl/qec_checker.sv
`timescale 1ns/1ps
module qec_checker #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                step_valid,
  input logic                step_up,
  input logic                enc_idx,
  input logic [1:0]          sync_mode,
  input logic signed [W-1:0] start_val,
  input logic signed [W-1:0] lim_lo,
  input logic signed [W-1:0] lim_hi,
  input logic [4:0]          st_clr,
  input logic [4:0]          irq_mask,
  input logic signed [W-1:0] count,
  input logic                cmp_out,
  input logic [4:0]          ev_status,
  input logic                irq
);
  p_sync_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode == 2'd1 && $rose(enc_idx)) |=> (count == $past(start_val)));

  p_wrap_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode == 2'd0 && step_valid && step_up && count >= lim_hi)
      |=> (count == $past(lim_lo) && ev_status[1]));

  p_wrap_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode == 2'd0 && step_valid && !step_up && count <= lim_lo)
      |=> (count == $past(lim_hi) && ev_status[2]));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode == 2'd0 && !step_valid) |=> $stable(count));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_status & ($past(ev_status) & ~$past(st_clr)))
              == ($past(ev_status) & ~$past(st_clr))));

  p_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 5'd0) |-> !irq);

  p_cmp_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_out) |-> ev_status[0]);
endmodule

bind encoder_event_counter qec_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_up(step_up),
  .enc_idx(enc_idx), .sync_mode(sync_mode), .start_val(start_val),
  .lim_lo(lim_lo), .lim_hi(lim_hi), .st_clr(st_clr), .irq_mask(irq_mask),
  .count(count), .cmp_out(cmp_out), .ev_status(ev_status), .irq(irq)
);

// File: tb/sim_encoder_event_counter.sv
`timescale 1ns/1ps
module sim_encoder_event_counter;
  localparam int W = 8;
  localparam logic signed [W-1:0] LIM_LO = -8'sd5;
  localparam logic signed [W-1:0] LIM_HI = 8'sd6;
  localparam logic signed [W-1:0] START  = 8'sd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_valid = 0, step_up = 0, enc_idx = 0, gate_in = 0, sync_fall = 0;
  logic [1:0] sync_mode = 2'd0;
  logic cmp_wr_en = 0, cmp_wr_sel = 0;
  logic signed [W-1:0] cmp_wr_data = '0;
  logic [4:0] st_clr = '0, irq_mask = '0;
  logic step_ready, cmp_out, irq;
  logic signed [W-1:0] count;
  logic [4:0] ev_status;

  always #2.5 clk = ~clk;

  encoder_event_counter #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_ready(step_ready),
    .step_up(step_up), .enc_idx(enc_idx), .gate_in(gate_in),
    .sync_mode(sync_mode), .sync_fall(sync_fall), .start_val(START),
    .lim_lo(LIM_LO), .lim_hi(LIM_HI), .cmp_wr_en(cmp_wr_en),
    .cmp_wr_sel(cmp_wr_sel), .cmp_wr_data(cmp_wr_data), .st_clr(st_clr),
    .irq_mask(irq_mask), .count(count), .cmp_out(cmp_out),
    .ev_status(ev_status), .irq(irq)
  );

  int vectors = 0, errors = 0;
  bit done = 0;
  string req = "R1";

  // reference state
  logic signed [W-1:0] cnt_m = '0, lo_m = '0, hi_m = -8'sd1;
  logic co_m = 0, hd_m = 0, lu_m = 0, pidx = 0, pg = 0;
  logic [4:0] st_m = '0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(string what, int act, int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    logic signed [W-1:0] nx;
    logic [4:0] ev;
    logic sp, ir, win;
    ir = enc_idx & ~pidx;
    case (sync_mode)
      2'd0: sp = 1'b0;
      2'd1: sp = ir;
      2'd2: sp = ir & gate_in;
      default: sp = sync_fall ? (~gate_in & pg) : (gate_in & ~pg);
    endcase
    ev = '0;
    nx = cnt_m;
    if (sp) nx = START;
    else if (step_valid) begin
      if (step_up) begin
        if (cnt_m >= LIM_HI) begin nx = LIM_LO; ev[1] = 1'b1; end
        else nx = cnt_m + 8'sd1;
      end else begin
        if (cnt_m <= LIM_LO) begin nx = LIM_HI; ev[2] = 1'b1; end
        else nx = cnt_m - 8'sd1;
      end
      if (nx == 0) ev[3] = 1'b1;
      if (hd_m && step_up != lu_m) ev[4] = 1'b1;
      hd_m = 1'b1;
      lu_m = step_up;
    end
    win = (cnt_m >= lo_m) && (cnt_m <= hi_m);
    ev[0] = win & ~co_m;
    co_m = win;
    st_m = (st_m & ~st_clr) | ev;
    if (cmp_wr_en) begin
      if (cmp_wr_sel) hi_m = cmp_wr_data;
      else lo_m = cmp_wr_data;
    end
    cnt_m = nx;
    pidx = enc_idx;
    pg = gate_in;
    @(posedge clk);
    @(negedge clk);
    vectors++;
    chk("count", int'(count), int'(cnt_m));
    chk("cmp_out", int'(cmp_out), int'(co_m));
    chk("ev_status", int'(ev_status), int'(st_m));
    chk("irq", int'(irq), int'(|(st_m & irq_mask)));
    chk("step_ready R2", int'(step_ready), 1);
  endtask

  task automatic lfsr();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    req = "R1";
    vectors++;
    chk("count", int'(count), 0);
    chk("cmp_out", int'(cmp_out), 0);
    chk("ev_status", int'(ev_status), 0);
    chk("irq", int'(irq), 0);
    chk("step_ready", int'(step_ready), 1);
    rst_n = 1'b1;
    tick();

    // R2 R3 R5: up sweep past the high bound, empty window
    req = "R2/R3/R5";
    irq_mask = 5'b11111;
    step_valid = 1; step_up = 1;
    repeat (15) tick();
    step_valid = 0;
    repeat (2) tick();

    // R7 R8: program window [2,4] then sweep through it
    req = "R7/R8";
    cmp_wr_en = 1; cmp_wr_sel = 0; cmp_wr_data = 8'sd2; tick();
    cmp_wr_sel = 1; cmp_wr_data = 8'sd4; tick();
    cmp_wr_en = 0;
    st_clr = 5'b11111; tick(); st_clr = '0;
    step_valid = 1; step_up = 1;
    repeat (14) tick();

    // R4 R6: down sweep past the low bound, direction reversal
    req = "R4/R6/R5";
    step_up = 0;
    repeat (30) tick();

    // R10: clear while an overflow happens in the same cycle
    req = "R10";
    step_valid = 0;
    st_clr = 5'b11111; tick(); st_clr = '0;
    step_valid = 1; step_up = 1;
    while (cnt_m < LIM_HI) tick();
    st_clr = 5'b00010; tick();
    st_clr = 5'b00010; step_valid = 0; tick();
    st_clr = '0;

    // R11: every mask value against a fixed status
    req = "R11";
    step_valid = 1; step_up = 0; tick(); tick();
    step_valid = 0;
    st_clr = 5'b00100; tick(); st_clr = '0;
    for (int m = 0; m < 32; m++) begin
      irq_mask = 5'(m);
      tick();
    end

    // R9: every sync mode and edge select with pseudo-random pins
    req = "R9";
    irq_mask = 5'b10101;
    for (int md = 0; md < 4; md++) begin
      for (int f = 0; f < 2; f++) begin
        sync_mode = 2'(md);
        sync_fall = f[0];
        repeat (40) begin
          lfsr();
          enc_idx = lf[0]; gate_in = lf[1];
          step_valid = lf[2]; step_up = lf[3];
          tick();
        end
      end
    end

    // R2..R11 mixed: random steps, window writes, clears
    req = "R2/R3/R4/R5/R6/R7/R8/R9/R10/R11";
    sync_mode = 2'd0; enc_idx = 0; gate_in = 0;
    repeat (600) begin
      lfsr();
      step_valid = lf[2] | lf[9];
      step_up = lf[3] ^ (lf[14] & lf[15]);
      cmp_wr_en = lf[4] & lf[5];
      cmp_wr_sel = lf[6];
      cmp_wr_data = {{4{lf[11]}}, lf[11:8]};
      st_clr = (lf[7:5] == 3'd0) ? lf[12:8] : 5'd0;
      irq_mask = lf[15:11];
      tick();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule